// File: doc/BRIEF.md
# Serial-Protocol Engine for a Differential SAR Converter

This block is a synthesizable model of the digital side of a 14-bit successive-approximation converter that talks to its host over a three-wire serial link. The host's chip-select and serial clock pins are brought into the system-clock domain through two-flop synchronizers. Every protocol decision is made from edges of those synchronized copies. A 14-bit parallel word, `sample_in`, stands in for the analog input and is captured when a frame opens. The block can serve as a device under test or as a stand-in converter next to a host controller.

The engine is built around three states: acquiring (`ST_ACQ`), converting (`ST_CNV`) and offset calibration (`ST_OFFCAL`). The named transitions are:
- START: `ST_ACQ` to `ST_CNV` on a chip-select fall.
- DONE: `ST_CNV` to `ST_ACQ` on the 18th serial-clock fall of the frame.
- SHORT: `ST_CNV` to `ST_ACQ` when chip select rises early.
- CAL: `ST_ACQ` to `ST_OFFCAL` when the fall count in the open frame reaches the calibration threshold. The threshold is 24 in the first frame after reset and 64 in any later frame.
- CALDONE: `ST_OFFCAL` to `ST_ACQ` when chip select rises.

A frame that closes in `ST_ACQ` after DONE but before CAL has aborted its calibration and changes nothing. During each frame the engine shifts out the result of the previous conversion. That result is the captured sample minus the stored offset, saturated to 14-bit two's complement.

Top module: `sar_serial_slave`

## Requirements
- R1: After reset, and whenever chip select is idle high, `state_o` reads ACQ and `offset_o` holds its last value (zero after reset). `state_o` is encoded as ACQ=0, CNV=1, OFFCAL=2.
- R2: While chip select is high, `sdo_oe` is 0 and `sdo` is 0.
- R3: A chip-select fall captures `sample_in`, moves the engine to CNV, raises `sdo_oe` and drives a leading 0 on `sdo`.
- R4: The engine stays in CNV through the first 17 serial-clock falls of a frame and returns to ACQ on the 18th.
- R5: The word of the previous conversion leaves MSB first. Its bit 13-k+1 is on `sdo` after rising edge k, for k=1..14, and `sdo` is 0 after every later rising edge of the frame.
- R6: The first frame after reset sends a word of all zeros.
- R7: If a frame closes with fewer than 18 falls, the following frame sends 14'h3FFF in place of a result.
- R8: If the first frame after reset reaches 24 falls, the engine is in OFFCAL from the 24th fall onward. At chip-select rise, `offset_o` takes `sample_in` and the engine returns to ACQ.
- R9: In any later frame, reaching 64 falls enters OFFCAL, and the rise then latches `sample_in` into `offset_o`. The previous result is still sent in that frame's first bits.
- R10: A calibration is aborted, leaving `offset_o` unchanged and the state ACQ, if the first frame closes after 18 to 23 falls or a later frame closes after 18 to 63 falls.
- R11: A frame with at least 18 falls stores the result sample minus offset (the offset in force at the 18th fall), clamped to the range -8192..8191. The next frame sends this result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| cs_n | input | 1 | Chip select from the host, active low |
| sclk | input | 1 | Serial clock from the host, idles high |
| sample_in | input | 14 | Two's-complement word standing in for the analog sample |
| sdo | output | 1 | Serial data bit, 0 when not enabled |
| sdo_oe | output | 1 | Output enable for `sdo` (1 = drive, 0 = high impedance) |
| state_o | output | 2 | Engine state: 0 ACQ, 1 CNV, 2 OFFCAL |
| offset_o | output | 14 | Stored offset-correction value |

## Verification
A pin edge passes through two synchronizer flops and an edge register before it acts. State, counter and serial-bit updates are therefore due three system clocks after the pin changes, while `sdo_oe` follows chip select after two. The bench holds each serial-clock and chip-select phase for four system clocks and samples on the falling clock edge at the end of the phase. Every result is thus read one cycle after it is due, and before the next pin change. The state is checked after every serial-clock fall, each output bit after every rise, and the offset after each frame closes. A bench model computes the saturated difference and applies the calibration thresholds.

// File: rtl/sarx_pkg.sv
package sarx_pkg;

    // Engine states; the numeric codes are visible on the state output.
    typedef enum logic [1:0] {
        ST_ACQ    = 2'd0,
        ST_CNV    = 2'd1,
        ST_OFFCAL = 2'd2
    } eng_state_t;

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
    parameter int STAGES = 2,
    parameter bit IDLE   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= IDLE;
        else        chain[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= IDLE;
            else        chain[g] <= chain[g-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last <= IDLE;
        else        last <= chain[STAGES-1];
    end

    assign lvl  = chain[STAGES-1];
    assign rise = lvl & ~last;
    assign fall = ~lvl & last;

endmodule

// File: rtl/frame_fsm.sv
module frame_fsm
    import sarx_pkg::*;
#(
    parameter int CONV_EDGES = 18,
    parameter int CAL_BOOT   = 24,
    parameter int CAL_RUN    = 64,
    localparam int CW        = $clog2(CAL_RUN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_lvl,
    input  logic          cs_fall,
    input  logic          cs_rise,
    input  logic          sck_fall,
    output eng_state_t    state,
    output logic          armed,
    output logic          frame_start,
    output logic          conv_done,
    output logic          short_end,
    output logic          cal_done
);
    localparam logic [CW-1:0] N_CONV = CW'(CONV_EDGES);
    localparam logic [CW-1:0] N_BOOT = CW'(CAL_BOOT);
    localparam logic [CW-1:0] N_RUN  = CW'(CAL_RUN);

    eng_state_t    state_q, state_d;
    logic [CW-1:0] edge_cnt_q, cnt_inc, thr;
    logic          boot_q, boot_frame_q;

    assign cnt_inc = (edge_cnt_q == N_RUN) ? edge_cnt_q : edge_cnt_q + 1'b1;
    assign thr     = boot_frame_q ? N_BOOT : N_RUN;

    // Next state and transition pulses.
    always_comb begin
        state_d     = state_q;
        frame_start = 1'b0;
        conv_done   = 1'b0;
        short_end   = 1'b0;
        cal_done    = 1'b0;
        unique case (state_q)
            ST_ACQ: begin
                if (cs_fall) begin
                    state_d     = ST_CNV;           // START
                    frame_start = 1'b1;
                end else if (!cs_lvl && sck_fall && cnt_inc == thr) begin
                    state_d     = ST_OFFCAL;        // CAL
                end
            end
            ST_CNV: begin
                if (cs_rise) begin
                    state_d     = ST_ACQ;           // SHORT
                    short_end   = 1'b1;
                end else if (sck_fall && cnt_inc == N_CONV) begin
                    state_d     = ST_ACQ;           // DONE
                    conv_done   = 1'b1;
                end
            end
            ST_OFFCAL: begin
                if (cs_rise) begin
                    state_d     = ST_ACQ;           // CALDONE
                    cal_done    = 1'b1;
                end
            end
            default: state_d = ST_ACQ;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ACQ;
        else        state_q <= state_d;
    end

    // Frame bookkeeping: fall counter and first-frame flags.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_cnt_q   <= '0;
            boot_q       <= 1'b1;
            boot_frame_q <= 1'b0;
        end else if (frame_start) begin
            edge_cnt_q   <= '0;
            boot_q       <= 1'b0;
            boot_frame_q <= boot_q;
        end else if (!cs_lvl && sck_fall) begin
            edge_cnt_q   <= cnt_inc;
        end
    end

    assign state = state_q;
    assign armed = (edge_cnt_q != '0);

    AST_IDLE_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_lvl && $past(cs_lvl)) |-> state_q == ST_ACQ);              // R1
    AST_CNV_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CNV) |-> edge_cnt_q < N_CONV);                  // R4
    AST_CAL_THRESHOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFFCAL) |-> edge_cnt_q >= N_BOOT);              // R8

endmodule

// File: rtl/shift_datapath.sv
module shift_datapath #(
    parameter int             DW           = 14,
    parameter logic [DW-1:0]  INVALID_CODE = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] sample_in,
    input  logic          cs_lvl,
    input  logic          sck_rise,
    input  logic          armed,
    input  logic          frame_start,
    input  logic          conv_done,
    input  logic          short_end,
    input  logic          cal_done,
    output logic          sdo_bit,
    output logic [DW-1:0] offset_o
);
    localparam logic signed [DW:0] MAXV = (DW+1)'((1 << (DW-1)) - 1);
    localparam logic signed [DW:0] MINV = -MAXV - (DW+1)'(1);

    logic [DW-1:0]     held_q, offset_q, result_q, tx_q;
    logic              invalid_q;
    logic signed [DW:0] diff;
    logic [DW-1:0]     corrected;

    assign diff = $signed({held_q[DW-1], held_q}) - $signed({offset_q[DW-1], offset_q});

    always_comb begin
        if (diff > MAXV)      corrected = MAXV[DW-1:0];
        else if (diff < MINV) corrected = MINV[DW-1:0];
        else                  corrected = diff[DW-1:0];
    end

    // Serial launch path.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q  <= '0;
            tx_q    <= '0;
            sdo_bit <= 1'b0;
        end else if (frame_start) begin
            held_q  <= sample_in;
            tx_q    <= invalid_q ? INVALID_CODE : result_q;
            sdo_bit <= 1'b0;
        end else if (cs_lvl) begin
            sdo_bit <= 1'b0;
        end else if (sck_rise && armed) begin
            sdo_bit <= tx_q[DW-1];
            tx_q    <= {tx_q[DW-2:0], 1'b0};
        end
    end

    // Result, validity and offset storage.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q  <= '0;
            invalid_q <= 1'b0;
            offset_q  <= '0;
        end else begin
            if (conv_done) result_q <= corrected;
            if (short_end)      invalid_q <= 1'b1;
            else if (conv_done) invalid_q <= 1'b0;
            if (cal_done) offset_q <= sample_in;
        end
    end

    assign offset_o = offset_q;

    AST_LEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (sdo_bit == 1'b0));                            // R3
    AST_OFFSET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_done |=> $stable(offset_q));                              // R10

endmodule

// File: rtl/sar_serial_slave.sv
module sar_serial_slave
    import sarx_pkg::*;
#(
    parameter int DW         = 14,
    parameter int SYNC_STAGES = 2,
    parameter int CONV_EDGES = 18,
    parameter int CAL_BOOT   = 24,
    parameter int CAL_RUN    = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          sclk,
    input  logic [DW-1:0] sample_in,
    output logic          sdo,
    output logic          sdo_oe,
    output logic [1:0]    state_o,
    output logic [DW-1:0] offset_o
);
    logic       cs_lvl, cs_rise, cs_fall;
    logic       sck_lvl, sck_rise, sck_fall;
    logic       armed, frame_start, conv_done, short_end, cal_done, sdo_bit;
    eng_state_t state;

    edge_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_cs_sync (
        .clk(clk), .rst_n(rst_n), .d(cs_n),
        .lvl(cs_lvl), .rise(cs_rise), .fall(cs_fall));

    edge_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sck_sync (
        .clk(clk), .rst_n(rst_n), .d(sclk),
        .lvl(sck_lvl), .rise(sck_rise), .fall(sck_fall));

    frame_fsm #(.CONV_EDGES(CONV_EDGES), .CAL_BOOT(CAL_BOOT), .CAL_RUN(CAL_RUN)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cs_lvl(cs_lvl), .cs_fall(cs_fall), .cs_rise(cs_rise), .sck_fall(sck_fall),
        .state(state), .armed(armed), .frame_start(frame_start),
        .conv_done(conv_done), .short_end(short_end), .cal_done(cal_done));

    shift_datapath #(.DW(DW)) u_dp (
        .clk(clk), .rst_n(rst_n), .sample_in(sample_in),
        .cs_lvl(cs_lvl), .sck_rise(sck_rise), .armed(armed),
        .frame_start(frame_start), .conv_done(conv_done),
        .short_end(short_end), .cal_done(cal_done),
        .sdo_bit(sdo_bit), .offset_o(offset_o));

    assign sdo_oe  = ~cs_lvl;
    assign sdo     = sdo_oe & sdo_bit;
    assign state_o = state;

    AST_LAUNCH_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sck_lvl && !cs_lvl) |=> (cs_lvl || $stable(sdo_bit)));       // R5

endmodule

// File: tb/sar_serial_slave_test.sv
module sar_serial_slave_test;
    logic        clk = 1'b0;
    logic        rst_n, cs_n, sclk;
    logic [13:0] sample_in;
    logic        sdo, sdo_oe;
    logic [1:0]  state_o;
    logic [13:0] offset_o;

    int n_chk = 0, n_bad = 0;
    bit done  = 1'b0;
    int m_word, m_off;
    bit m_boot;

    localparam int H = 4;

    always #5 clk = ~clk;

    sar_serial_slave uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sample_in(sample_in),
        .sdo(sdo), .sdo_oe(sdo_oe), .state_o(state_o), .offset_o(offset_o));

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int sat14(input int v);
        if (v > 8191)  return 8191;
        if (v < -8192) return -8192;
        return v;
    endfunction

    task automatic wait_h();
        repeat (H) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b1; sample_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        wait_h();
        m_word = 0; m_off = 0; m_boot = 1'b1;
    endtask

    task automatic run_frame(input int n, input int smp, input string wtag);
        int thr, sends, got, tail;
        thr = m_boot ? 24 : 64;
        sends = m_word; got = 0; tail = 0;
        sample_in = smp[13:0];
        cs_n = 1'b0;
        wait_h();
        check("R3 oe", int'(sdo_oe), 1);
        check("R3 lead", int'(sdo), 0);
        check("R3 state", int'(state_o), 1);
        for (int i = 1; i <= n; i++) begin
            sclk = 1'b0;
            wait_h();
            if (i < 18)       check("R4 state", int'(state_o), 1);
            else if (i >= thr) check(m_boot ? "R8 state" : "R9 state", int'(state_o), 2);
            else              check("R10 state", int'(state_o), 0);
            sclk = 1'b1;
            wait_h();
            if (i <= 14) got = (got << 1) | int'(sdo);
            else         tail = tail | int'(sdo);
        end
        if (n >= 14) check(wtag, got, sends & 'h3FFF);
        if (n > 14)  check("R5 tail", tail, 0);
        cs_n = 1'b1;
        wait_h();
        check("R2 oe", int'(sdo_oe), 0);
        check("R2 sdo", int'(sdo), 0);
        check("R1 idle", int'(state_o), 0);
        if (n < 18) m_word = 'h3FFF;
        else        m_word = sat14(smp - m_off) & 'h3FFF;
        if (n >= thr) m_off = smp;
        check(n >= thr ? (thr == 24 ? "R8 offset" : "R9 offset") : "R10 offset",
              int'(offset_o), m_off & 'h3FFF);
        m_boot = 1'b0;
    endtask

    task automatic sweep(input string tag);
        for (int k = 0; k < 64; k++)
            run_frame(18, (k == 63) ? 8191 : -8192 + k * 260, tag);
    endtask

    initial begin
        do_reset();
        check("R1 state", int'(state_o), 0);
        check("R1 offset", int'(offset_o), 0);
        check("R2 oe", int'(sdo_oe), 0);
        // boot frame of 20 clocks: zero word, calibration aborted
        run_frame(20, 1234, "R6 word");
        run_frame(18, 55, "R5 word");
        // boot calibration with 24 clocks
        do_reset();
        run_frame(24, 100, "R6 word");
        sweep("R11 word");
        run_frame(10, 7, "R5 word");          // short frame
        run_frame(18, 500, "R7 word");        // invalid code expected
        run_frame(40, 600, "R5 word");        // in-service abort
        run_frame(64, -3000, "R9 word");      // in-service calibration
        sweep("R11 word");
        run_frame(64, 3000, "R9 word");
        sweep("R11 word");
        run_frame(18, 0, "R11 word");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R5 watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule